// File: doc/BRIEF.md
# Fuse Strobe Timing Sequencer

This block paces one access to a one-time-programmable fuse array. A start command and an access type (read or program) launch a fixed four-phase sequence: a leading relax interval, the active strobe pulse, a trailing relax interval and a closing wait interval. After the wait interval a single done cycle follows. Software loads four timing fields that are counted in clock cycles. The relax and wait fields apply to both access types. Each access type has its own strobe field.

A strobe field gives the length of the whole strobe window. That window includes a relax period on each side of the active pulse. The active pulse is therefore the strobe window minus two relax periods. A field value N means N+1 clock cycles. Typical settings keep relax at 100 ns or more and wait at 150 ns or more. A read pulse is about 40 ns, and a program pulse lies between 9 and 11 us. The block captures every field on the cycle a start is accepted, so later writes to the fields cannot disturb an access that is already running.

Top module: `fuse_strobe_seq`

## Requirements
- R1: After reset, busy_o, done_o, strobe_o, cfg_err_o and overlap_err_o are 0 and phase_o is 0 (idle).
- R2: After a start is accepted, phase_o is 1 (leading relax) for exactly relax+1 cycles, starting on the cycle after the accepting edge.
- R3: Phase 2 (active) follows for exactly max(S+1-2*(relax+1), 1) cycles, and strobe_o is high in those cycles and in no others. S is the read strobe field when prog_i=0 and the program strobe field when prog_i=1.
- R4: Phase 3 (trailing relax) follows for exactly relax+1 cycles.
- R5: Phase 4 (wait) follows for exactly wait+1 cycles.
- R6: Next comes exactly one cycle with phase_o=5, done_o=1 and busy_o=0, and then phase_o returns to 0. busy_o is 1 exactly while phase_o is 1 to 4.
- R7: The access type and all four fields are sampled on the accepting edge. Changes to them during the access have no effect on that access.
- R8: cfg_err_o is set for an access whose selected strobe field is below 2*(relax+1). It is cleared for an access whose field is not below that value. It changes only on an accepted start.
- R9: A start while busy_o=1 is ignored, and it sets overlap_err_o, which stays 1 until reset.
- R10: A start is accepted both in idle and in the done cycle, so accesses can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request |
| prog_i | input | 1 | Access type: 1 program, 0 read |
| relax_i | input | RELAX_W | Relax field (cycles minus one) |
| wait_i | input | WAIT_W | Wait field (cycles minus one) |
| rd_strobe_i | input | STRB_W | Read strobe window field |
| pg_strobe_i | input | STRB_W | Program strobe window field |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| strobe_o | output | 1 | Active strobe to the fuse array |
| phase_o | output | 3 | Phase code: 0 idle, 1 lead, 2 active, 3 trail, 4 wait, 5 done |
| cfg_err_o | output | 1 | Strobe window too short for the last access |
| overlap_err_o | output | 1 | Sticky: start seen while busy |

## Verification
The bench builds the block with its default widths: 6-bit relax and wait fields and a 12-bit strobe field. Those widths are enough for a 2000-cycle program pulse at a 200 MHz clock, which the bench runs once in addition to short random windows. Random relax values are kept small so that windows just below, at and just above the 2*(relax+1) limit come up often. Directed cases add the largest relax and wait values, a start in the done cycle, and starts issued in the middle of an access.

// File: rtl/fsst_pkg.sv
package fsst_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LEAD   = 3'd1,
        PH_ACTIVE = 3'd2,
        PH_TRAIL  = 3'd3,
        PH_WAIT   = 3'd4,
        PH_DONE   = 3'd5
    } phase_e;

    // Cycles in both relax margins of a strobe window.
    function automatic int unsigned margin_cycles(int unsigned relax);
        return 2 * (relax + 1);
    endfunction

    // Active pulse length minus one; a short window clamps to one cycle.
    function automatic int unsigned active_m1(int unsigned win, int unsigned relax);
        if (win >= margin_cycles(relax))
            return win - margin_cycles(relax);
        return 0;
    endfunction

    function automatic logic window_short(int unsigned win, int unsigned relax);
        return win < margin_cycles(relax);
    endfunction

endpackage

// File: rtl/fsst_cfg_hold.sv
module fsst_cfg_hold #(
    parameter int RELAX_W = 6,
    parameter int WAIT_W  = 6,
    parameter int STRB_W  = 12,
    parameter int CNT_W   = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture_i,
    input  logic               prog_i,
    input  logic [RELAX_W-1:0] relax_i,
    input  logic [WAIT_W-1:0]  wait_i,
    input  logic [STRB_W-1:0]  rd_strobe_i,
    input  logic [STRB_W-1:0]  pg_strobe_i,
    output logic [CNT_W-1:0]   relax_q,
    output logic [CNT_W-1:0]   wait_q,
    output logic [CNT_W-1:0]   active_q,
    output logic               short_q
);
    typedef struct packed {
        logic [CNT_W-1:0] relax;
        logic [CNT_W-1:0] waitc;
        logic [CNT_W-1:0] active;
        logic             short_win;
    } held_t;

    held_t            held, held_d;
    logic [STRB_W-1:0] win_sel;

    always_comb begin
        win_sel          = prog_i ? pg_strobe_i : rd_strobe_i;
        held_d.relax     = CNT_W'(relax_i);
        held_d.waitc     = CNT_W'(wait_i);
        held_d.active    = CNT_W'(fsst_pkg::active_m1(32'(win_sel), 32'(relax_i)));
        held_d.short_win = fsst_pkg::window_short(32'(win_sel), 32'(relax_i));
    end

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (capture_i)
            held <= held_d;
    end

    assign relax_q  = held.relax;
    assign wait_q   = held.waitc;
    assign active_q = held.active;
    assign short_q  = held.short_win;

    // R7: held timing only moves on a capture
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !capture_i |=> $stable(held));

endmodule

// File: rtl/fsst_down_cnt.sv
module fsst_down_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load_i)
            cnt <= load_val_i;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);

    // R2: a loaded count of zero gives a one-cycle phase
    p_zero_load_r2: assert property (@(posedge clk) disable iff (rst)
        load_i && (load_val_i == '0) |=> zero_o);
    // R3: a non-zero load never reports zero on the next cycle
    p_nonzero_load_r3: assert property (@(posedge clk) disable iff (rst)
        load_i && (load_val_i != '0) |=> !zero_o);

endmodule

// File: rtl/fuse_strobe_seq.sv
module fuse_strobe_seq #(
    parameter int RELAX_W = 6,
    parameter int WAIT_W  = 6,
    parameter int STRB_W  = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               prog_i,
    input  logic [RELAX_W-1:0] relax_i,
    input  logic [WAIT_W-1:0]  wait_i,
    input  logic [STRB_W-1:0]  rd_strobe_i,
    input  logic [STRB_W-1:0]  pg_strobe_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               strobe_o,
    output logic [2:0]         phase_o,
    output logic               cfg_err_o,
    output logic               overlap_err_o
);
    import fsst_pkg::*;

    localparam int RW_MAX = (RELAX_W > WAIT_W) ? RELAX_W : WAIT_W;
    localparam int CNT_W  = (STRB_W > RW_MAX) ? STRB_W : RW_MAX;

    phase_e           phase, phase_n;
    logic             accept, cnt_zero, cnt_load, overlap_q;
    logic [CNT_W-1:0] cnt_val, relax_q, wait_q, active_q;

    assign busy_o = (phase == PH_LEAD) || (phase == PH_ACTIVE) ||
                    (phase == PH_TRAIL) || (phase == PH_WAIT);
    assign accept = start_i && !busy_o;

    fsst_cfg_hold #(
        .RELAX_W(RELAX_W), .WAIT_W(WAIT_W), .STRB_W(STRB_W), .CNT_W(CNT_W)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .capture_i  (accept),
        .prog_i     (prog_i),
        .relax_i    (relax_i),
        .wait_i     (wait_i),
        .rd_strobe_i(rd_strobe_i),
        .pg_strobe_i(pg_strobe_i),
        .relax_q    (relax_q),
        .wait_q     (wait_q),
        .active_q   (active_q),
        .short_q    (cfg_err_o)
    );

    always_comb begin
        phase_n  = phase;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (phase)
            PH_IDLE, PH_DONE: begin
                if (accept) begin
                    phase_n  = PH_LEAD;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(relax_i);
                end else begin
                    phase_n = PH_IDLE;
                end
            end
            PH_LEAD: if (cnt_zero) begin
                phase_n  = PH_ACTIVE;
                cnt_load = 1'b1;
                cnt_val  = active_q;
            end
            PH_ACTIVE: if (cnt_zero) begin
                phase_n  = PH_TRAIL;
                cnt_load = 1'b1;
                cnt_val  = relax_q;
            end
            PH_TRAIL: if (cnt_zero) begin
                phase_n  = PH_WAIT;
                cnt_load = 1'b1;
                cnt_val  = wait_q;
            end
            PH_WAIT: if (cnt_zero) phase_n = PH_DONE;
            default: phase_n = PH_IDLE;
        endcase
    end

    fsst_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load_i    (cnt_load),
        .load_val_i(cnt_val),
        .zero_o    (cnt_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            overlap_q <= 1'b0;
        end else begin
            phase <= phase_n;
            if (start_i && busy_o)
                overlap_q <= 1'b1;
        end
    end

    assign done_o        = (phase == PH_DONE);
    assign strobe_o      = (phase == PH_ACTIVE);
    assign phase_o       = phase;
    assign overlap_err_o = overlap_q;

    // R6: done lasts one cycle and only follows the wait phase
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    p_done_after_wait_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(phase) == PH_WAIT);
    // R3: the strobe only rises out of the leading relax phase
    p_strobe_after_lead_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_o) |-> $past(phase) == PH_LEAD);
    // R9: overlap flag is sticky, and a busy start never restarts the lead
    p_overlap_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overlap_err_o |=> overlap_err_o);
    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        start_i && busy_o && (phase != PH_IDLE) && !cnt_zero |=> phase == $past(phase));

endmodule

// File: tb/fuse_strobe_seq_tb.sv
module fuse_strobe_seq_tb;
    localparam int RELAX_W = 6;
    localparam int WAIT_W  = 6;
    localparam int STRB_W  = 12;

    logic clk = 1'b0;
    logic rst;
    logic start_i, prog_i;
    logic [RELAX_W-1:0] relax_i;
    logic [WAIT_W-1:0]  wait_i;
    logic [STRB_W-1:0]  rd_strobe_i, pg_strobe_i;
    logic busy_o, done_o, strobe_o, cfg_err_o, overlap_err_o;
    logic [2:0] phase_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fuse_strobe_seq #(.RELAX_W(RELAX_W), .WAIT_W(WAIT_W), .STRB_W(STRB_W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .prog_i(prog_i),
        .relax_i(relax_i), .wait_i(wait_i),
        .rd_strobe_i(rd_strobe_i), .pg_strobe_i(pg_strobe_i),
        .busy_o(busy_o), .done_o(done_o), .strobe_o(strobe_o), .phase_o(phase_o),
        .cfg_err_o(cfg_err_o), .overlap_err_o(overlap_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_active(int s, int r);
        return (s + 1 > 2 * (r + 1)) ? s + 1 - 2 * (r + 1) : 1;
    endfunction

    function automatic int exp_short(int s, int r);
        return (s < 2 * (r + 1)) ? 1 : 0;
    endfunction

    // Called at a negedge; ends at the negedge where the done cycle is seen.
    // poke >= 0 issues a start with scrambled settings at that busy cycle.
    task automatic run_access(input bit prog, input int r, input int w,
                              input int srd, input int spg, input int poke);
        int n_lead = 0, n_act = 0, n_trail = 0, n_wait = 0, n_strb = 0;
        int idx = 0, bad_busy = 0, s;
        s = prog ? spg : srd;
        start_i     = 1'b1;
        prog_i      = prog;
        relax_i     = RELAX_W'(r);
        wait_i      = WAIT_W'(w);
        rd_strobe_i = STRB_W'(srd);
        pg_strobe_i = STRB_W'(spg);
        @(negedge clk);
        start_i = 1'b0;
        // R7: scramble the settings once the access has started
        prog_i      = ~prog;
        relax_i     = RELAX_W'($urandom);
        wait_i      = WAIT_W'($urandom);
        rd_strobe_i = STRB_W'($urandom_range(0, 3));
        pg_strobe_i = STRB_W'($urandom_range(0, 3));
        while (phase_o != 3'd5 && idx < 20000) begin
            case (phase_o)
                3'd1: n_lead++;
                3'd2: n_act++;
                3'd3: n_trail++;
                3'd4: n_wait++;
                default: bad_busy++;
            endcase
            if (strobe_o) n_strb++;
            if (!busy_o) bad_busy++;
            start_i = (idx == poke);
            idx++;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(n_lead == r + 1, "R2 lead cycles", n_lead, r + 1);
        chk(n_act == exp_active(s, r), "R3 active cycles", n_act, exp_active(s, r));
        chk(n_strb == exp_active(s, r), "R3 strobe cycles", n_strb, exp_active(s, r));
        chk(n_trail == r + 1, "R4 trail cycles", n_trail, r + 1);
        chk(n_wait == w + 1, "R5 wait cycles", n_wait, w + 1);
        chk(bad_busy == 0, "R6 busy during phases 1-4", bad_busy, 0);
        chk(done_o && !busy_o && !strobe_o, "R6 done cycle", {done_o, busy_o}, 2);
        chk(int'(cfg_err_o) == exp_short(s, r), "R8 cfg_err", cfg_err_o, exp_short(s, r));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int r, w, a, b;
        void'($urandom(32'd1234));
        rst = 1'b1; start_i = 1'b0; prog_i = 1'b0;
        relax_i = '0; wait_i = '0; rd_strobe_i = '0; pg_strobe_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !strobe_o, "R1 outputs idle", {busy_o, done_o, strobe_o}, 0);
        chk(phase_o == 3'd0, "R1 phase", phase_o, 0);
        chk(!cfg_err_o && !overlap_err_o, "R1 error flags", {cfg_err_o, overlap_err_o}, 0);

        // Window boundary around 2*(relax+1): short, exact, one above
        run_access(1'b0, 3, 2, 7, 100, -1);   // R8 short window clamps to 1
        @(negedge clk);
        chk(phase_o == 3'd0 && !done_o, "R6 back to idle", phase_o, 0);
        run_access(1'b0, 3, 2, 8, 100, -1);   // R8 exact limit, no error
        @(negedge clk);
        run_access(1'b1, 3, 2, 0, 9, -1);     // R3 program field selected
        @(negedge clk);
        chk(!overlap_err_o, "R9 no overlap yet", overlap_err_o, 0);

        // R10 back-to-back: start issued in the done cycle
        run_access(1'b1, 1, 0, 3, 5, -1);
        run_access(1'b0, 0, 0, 0, 50, -1);
        @(negedge clk);

        // Largest relax and wait
        run_access(1'b0, 63, 63, 200, 0, -1);
        @(negedge clk);
        // Long program pulse: 2000 active cycles
        run_access(1'b1, 19, 29, 5, 2039, -1);
        @(negedge clk);

        // Random accesses
        for (int i = 0; i < 40; i++) begin
            r = $urandom_range(0, 7);
            w = $urandom_range(0, 15);
            a = $urandom_range(0, 40);
            b = $urandom_range(0, 60);
            run_access(1'($urandom_range(0, 1)), r, w, a, b, -1);
            if (i % 3 == 0) @(negedge clk);
        end
        @(negedge clk);
        chk(!overlap_err_o, "R9 no overlap before poke", overlap_err_o, 0);

        // R9 starts while busy are ignored; overlap flag sticks
        run_access(1'b0, 2, 3, 20, 4, 0);
        chk(overlap_err_o, "R9 overlap set", overlap_err_o, 1);
        @(negedge clk);
        run_access(1'b1, 4, 1, 2, 30, 12);
        @(negedge clk);
        chk(overlap_err_o, "R9 overlap sticky", overlap_err_o, 1);
        run_access(1'b0, 0, 5, 3, 3, 6);
        @(negedge clk);
        chk(phase_o == 3'd0, "R9 no restart after ignored start", phase_o, 0);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!overlap_err_o && !cfg_err_o && phase_o == 3'd0, "R1 reset clears flags",
            {overlap_err_o, cfg_err_o}, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule